// File: doc/BRIEF.md
# Single Transfer DMA Channel Engine

This block is one interrupt-driven DMA channel. It moves exactly one item per request. A trigger pulse tells the engine to fetch an 8-byte control block from memory through its byte-wide memory port. The engine checks that the control block is usable, then copies one byte or one little-endian word from the source pointer to the destination pointer. It then writes the new count and the two pointers back into the control block.

Each pointer has two options of its own. One decides whether the pointer advances, by the item size. The other decides whether the advanced value is stored back or the original value is kept for the next request. When the count in the control block reaches zero, the engine pulses `done` so that the interrupt logic can raise an end-of-service request. If the control block is unusable, the engine pulses `err`, leaves memory untouched and returns to idle.

A trigger that arrives while a transfer is running is remembered as one pending request. The engine serves it as soon as it is idle again.

The memory port is synchronous. A read issued with `mem_req` high and `mem_we` low returns its data on `mem_rdata` in the following cycle. A write with `mem_we` high takes effect at the same clock edge.

Top module: `single_xfer_engine`

## Requirements
- R1: The control block is laid out as follows: count at offset 0, control byte at offset 1, source pointer at offsets 2 (low byte) and 3 (high byte), destination pointer at offsets 4 (low) and 5 (high). The engine never writes offsets 1, 6 or 7.
- R2: Control-byte bits 7:5 are the mode field, and only the value 3'b100 is accepted. Any other value produces a one-cycle `err` pulse, no `done`, and no memory write.
- R3: Control bit 4 selects the item size, 1 for one byte and 0 for a two-byte word. A word is copied low byte first, from source+0 and source+1 to destination+0 and destination+1. Memory past the item is not written.
- R4: Control bit 1 (source) and bit 0 (destination) enable the pointer increment. The step is 1 for byte items and 2 for word items. With the bit clear, the pointer is not advanced.
- R5: Control bit 3 (source) and bit 2 (destination) select write-back. With the bit set, the advanced pointer is stored at its offsets. With the bit clear, the original pointer value is stored.
- R6: Each successful transfer stores the count minus one at offset 0.
- R7: `done` pulses for exactly one cycle after a transfer whose stored count is zero. It stays low for all other transfers.
- R8: A word transfer whose source or destination pointer is odd produces an `err` pulse and no memory write.
- R9: A request that finds a count of zero produces an `err` pulse and no memory write.
- R10: A control-block base address that is not a multiple of 8 produces an `err` pulse and no memory write.
- R11: Triggers that arrive while the engine is busy are merged into one pending request. That request is served after the current one, so any number of such triggers adds exactly one more transfer.
- R12: After reset, `done`, `err` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Transfer request pulse |
| cb_base | input | 16 | Byte address of the control block |
| mem_rdata | input | 8 | Read data, valid one cycle after a read request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable qualifying `mem_req` |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| done | output | 1 | One-cycle pulse when the count has reached zero |
| err | output | 1 | One-cycle pulse when a request was rejected |

## Verification
The properties assume three things about the environment:
- The memory answers every read in exactly the next cycle.
- `cb_base` is held steady while a request may be taken.
- No one else writes the control block or the data areas while the engine is busy.

The stimulus follows these rules. It changes the control block and memory only after each transfer has had time to finish. It changes `cb_base` only between requests. It keeps the source and destination areas apart from the control block, so a copy can never overwrite the block being served.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  localparam logic [2:0] MODE_SINGLE = 3'b100;
  localparam int         CB_USED     = 6;   // bytes of the control block actually read

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CB,
    ST_CHK,
    ST_SRD,
    ST_DWR,
    ST_WB,
    ST_FIN
  } state_e;

  // control byte, most significant field first
  typedef struct packed {
    logic [2:0] mode;
    logic       byte_sz;
    logic       src_keep;
    logic       dst_keep;
    logic       src_inc;
    logic       dst_inc;
  } ctl_t;

endpackage

// File: rtl/xfer_ctl_decode.sv
module xfer_ctl_decode
  import xfer_pkg::*;
#(
  parameter int AW     = 16,
  parameter int CNT_W  = 8,
  parameter int LSB_W  = 3
) (
  input  ctl_t             ctl,
  input  logic [CNT_W-1:0] count,
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    dst,
  input  logic [LSB_W-1:0] base_lo,
  output logic [1:0]       nbytes,
  output logic             fault
);

  logic bad_mode, bad_count, bad_align, bad_base;

  always_comb begin
    nbytes    = ctl.byte_sz ? 2'd1 : 2'd2;
    bad_mode  = (ctl.mode != MODE_SINGLE);
    bad_count = (count == '0);
    bad_align = !ctl.byte_sz && (src[0] || dst[0]);
    bad_base  = (base_lo != '0);
    fault     = bad_mode || bad_count || bad_align || bad_base;
  end

endmodule

// File: rtl/xfer_ptr_next.sv
module xfer_ptr_next #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] orig,
  input  logic [1:0]    step,
  input  logic          inc,
  input  logic          keep,
  output logic [AW-1:0] wb
);

  logic [AW-1:0] adv;

  assign adv = inc ? (orig + AW'(step)) : orig;
  assign wb  = keep ? adv : orig;

endmodule

// File: rtl/xfer_trig_latch.sv
module xfer_trig_latch (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic busy,
  output logic start,
  output logic pend_q
);

  assign start = !busy && (trig || pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (start) begin
      pend_q <= 1'b0;
    end else if (trig) begin
      pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/single_xfer_engine.sv
module single_xfer_engine
  import xfer_pkg::*;
#(
  parameter  int BYTE_W   = 8,
  parameter  int CB_BYTES = 8,
  localparam int AW       = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [AW-1:0]     cb_base,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              done,
  output logic              err
);

  localparam int CB_LSB = $clog2(CB_BYTES);

  state_e            st_q;
  logic [2:0]        idx_q;
  logic [AW-1:0]     base_q;
  logic [BYTE_W-1:0] cbb_q  [CB_USED];
  logic [BYTE_W-1:0] dbuf_q [2];
  logic              done_q, err_q;

  logic              busy, start, pend_q, in_wb;
  ctl_t              ctl;
  logic [BYTE_W-1:0] count, cnt_m1;
  logic [AW-1:0]     src_ptr, dst_ptr;
  logic [1:0]        nb;
  logic              fault;
  logic [2:0]        wb_off;

  logic [AW-1:0]     ptr_orig [2];
  logic [AW-1:0]     ptr_wb   [2];
  logic              ptr_inc  [2];
  logic              ptr_keep [2];

  assign busy    = (st_q != ST_IDLE);
  assign in_wb   = (st_q == ST_WB);
  assign ctl     = ctl_t'(cbb_q[1]);
  assign count   = cbb_q[0];
  assign cnt_m1  = count - 1'b1;
  assign src_ptr = {cbb_q[3], cbb_q[2]};
  assign dst_ptr = {cbb_q[5], cbb_q[4]};

  assign ptr_orig[0] = src_ptr;
  assign ptr_orig[1] = dst_ptr;
  assign ptr_inc[0]  = ctl.src_inc;
  assign ptr_inc[1]  = ctl.dst_inc;
  assign ptr_keep[0] = ctl.src_keep;
  assign ptr_keep[1] = ctl.dst_keep;

  xfer_trig_latch u_trig (
    .clk    (clk),
    .rst    (rst),
    .trig   (trig),
    .busy   (busy),
    .start  (start),
    .pend_q (pend_q)
  );

  xfer_ctl_decode #(
    .AW    (AW),
    .CNT_W (BYTE_W),
    .LSB_W (CB_LSB)
  ) u_dec (
    .ctl     (ctl),
    .count   (count),
    .src     (src_ptr),
    .dst     (dst_ptr),
    .base_lo (base_q[CB_LSB-1:0]),
    .nbytes  (nb),
    .fault   (fault)
  );

  for (genvar p = 0; p < 2; p++) begin : g_ptr
    xfer_ptr_next #(.AW(AW)) u_ptr (
      .orig (ptr_orig[p]),
      .step (nb),
      .inc  (ptr_inc[p]),
      .keep (ptr_keep[p]),
      .wb   (ptr_wb[p])
    );
  end

  // memory port: decoded from registered state only
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    wb_off    = 3'd0;
    case (st_q)
      ST_CB: begin
        if (idx_q < 3'(CB_USED)) begin
          mem_req  = 1'b1;
          mem_addr = base_q | AW'(idx_q);
        end
      end
      ST_SRD: begin
        if (idx_q < {1'b0, nb}) begin
          mem_req  = 1'b1;
          mem_addr = src_ptr + AW'(idx_q);
        end
      end
      ST_DWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_ptr + AW'(idx_q);
        mem_wdata = dbuf_q[idx_q[0]];
      end
      ST_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        case (idx_q)
          3'd0: begin wb_off = 3'd0; mem_wdata = cnt_m1;                    end
          3'd1: begin wb_off = 3'd2; mem_wdata = ptr_wb[0][BYTE_W-1:0];     end
          3'd2: begin wb_off = 3'd3; mem_wdata = ptr_wb[0][AW-1:BYTE_W];    end
          3'd3: begin wb_off = 3'd4; mem_wdata = ptr_wb[1][BYTE_W-1:0];     end
          default: begin wb_off = 3'd5; mem_wdata = ptr_wb[1][AW-1:BYTE_W]; end
        endcase
        mem_addr = base_q | AW'(wb_off);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      base_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q   <= ST_CB;
            idx_q  <= '0;
            base_q <= cb_base;
          end
        end
        ST_CB: begin
          if (idx_q == 3'(CB_USED)) begin
            st_q  <= ST_CHK;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_CHK: begin
          if (fault) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            st_q  <= ST_SRD;
            idx_q <= '0;
          end
        end
        ST_SRD: begin
          if (idx_q == {1'b0, nb}) begin
            st_q  <= ST_DWR;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_DWR: begin
          if (idx_q == {1'b0, 2'(nb - 2'd1)}) begin
            st_q  <= ST_WB;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_WB: begin
          if (idx_q == 3'd4) begin
            st_q <= ST_FIN;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_FIN: begin
          done_q <= (cnt_m1 == '0);
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // capture registers: no reset, plain register file
  always_ff @(posedge clk) begin
    if (st_q == ST_CB && idx_q != 3'd0) begin
      cbb_q[idx_q - 3'd1] <= mem_rdata;
    end
    if (st_q == ST_SRD && idx_q != 3'd0) begin
      dbuf_q[idx_q[1]] <= mem_rdata;
    end
  end

  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/single_xfer_engine_chk.sv
module single_xfer_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       trig,
  input logic       busy,
  input logic       pend,
  input logic       in_wb,
  input logic       mem_req,
  input logic       mem_we,
  input logic [2:0] addr_lo,
  input logic       done,
  input logic       err
);

  logic [3:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      wr_cnt <= '0;
    end else if (mem_req && mem_we) begin
      wr_cnt <= wr_cnt + 4'd1;
    end
  end

  // rejected requests (R2, R8, R9, R10) leave memory untouched
  assert_err_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    err |-> (wr_cnt == 4'd0));

  // a completed request wrote the item plus five control-block bytes
  assert_done_writes_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (wr_cnt == 4'd6 || wr_cnt == 4'd7));

  assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  assert_wb_offsets_R1: assert property (@(posedge clk) disable iff (rst)
    (in_wb && mem_req) |-> (addr_lo != 3'd1 && addr_lo < 3'd6));

  assert_pend_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && trig) |=> pend);

  assert_we_needs_req_R12: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

endmodule

bind single_xfer_engine single_xfer_engine_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .trig    (trig),
  .busy    (busy),
  .pend    (pend_q),
  .in_wb   (in_wb),
  .mem_req (mem_req),
  .mem_we  (mem_we),
  .addr_lo (mem_addr[2:0]),
  .done    (done),
  .err     (err)
);

// File: tb/test_single_xfer_engine.sv
module test_single_xfer_engine;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 1024;

  logic        clk = 1'b0;
  logic        rst;
  logic        trig;
  logic [15:0] cb_base;
  logic [7:0]  rdata_q;
  logic        mem_req, mem_we, done, err;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  logic [7:0]  mem [MEM_N];
  int          checks = 0;
  int          failures = 0;
  int          n_done = 0;
  int          n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  single_xfer_engine i_single_xfer_engine (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .cb_base   (cb_base),
    .mem_rdata (rdata_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .err       (err)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        rdata_q <= mem[mem_addr[9:0]];
    end
  end

  always @(posedge clk) begin
    if (done) n_done++;
    if (err)  n_err++;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic load_cb(input int b, input logic [7:0] ctl, input logic [7:0] cnt,
                         input logic [15:0] src, input logic [15:0] dst);
    mem[b]   = cnt;
    mem[b+1] = ctl;
    mem[b+2] = src[7:0];
    mem[b+3] = src[15:8];
    mem[b+4] = dst[7:0];
    mem[b+5] = dst[15:8];
    mem[b+6] = 8'hA6;
    mem[b+7] = 8'hA7;
    for (int k = 0; k < 3; k++) mem[int'(dst) + k] = 8'hEE;
  endtask

  task automatic pulse();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  // one request; tag names the rejection requirement expected, if any
  task automatic run(input string tag, input logic [7:0] ctl, input logic [7:0] cnt,
                     input logic [15:0] src, input logic [15:0] dst, input logic [15:0] base);
    int b, d0, e0, nb, step, esrc, edst;
    bit by, fault;
    b     = int'(base) & 16'hFFF8;
    by    = ctl[4];
    nb    = by ? 1 : 2;
    step  = nb;
    fault = (ctl[7:5] != 3'b100) || (cnt == 0) || (!by && (src[0] || dst[0])) ||
            (base[2:0] != 3'd0);
    load_cb(b, ctl, cnt, src, dst);
    cb_base = base;
    d0 = n_done;
    e0 = n_err;
    pulse();
    repeat (32) @(negedge clk);
    if (fault) begin
      chk(tag, "err pulses", n_err - e0, 1);
      chk(tag, "done pulses", n_done - d0, 0);
      chk(tag, "count untouched", int'(mem[b]), int'(cnt));
      chk(tag, "src untouched", int'({mem[b+3], mem[b+2]}), int'(src));
      chk(tag, "dst data untouched", int'(mem[int'(dst)]), 8'hEE);
    end else begin
      esrc = ctl[3] ? (ctl[1] ? int'(src) + step : int'(src)) : int'(src);
      edst = ctl[2] ? (ctl[0] ? int'(dst) + step : int'(dst)) : int'(dst);
      chk("R2", "no err on valid", n_err - e0, 0);
      chk("R7", "done pulses", n_done - d0, (cnt == 8'd1) ? 1 : 0);
      chk("R6", "count stored", int'(mem[b]), int'(cnt) - 1);
      chk("R5", "src stored", int'({mem[b+3], mem[b+2]}), esrc);
      chk("R4", "dst stored", int'({mem[b+5], mem[b+4]}), edst);
      for (int k = 0; k < nb; k++)
        chk("R3", "item byte", int'(mem[int'(dst) + k]), int'(pat(int'(src) + k)));
      chk("R3", "past item", int'(mem[int'(dst) + nb]), 8'hEE);
      chk("R1", "ctl kept", int'(mem[b+1]), int'(ctl));
      chk("R1", "byte6 kept", int'(mem[b+6]), 8'hA6);
      chk("R1", "byte7 kept", int'(mem[b+7]), 8'hA7);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int d0, e0;
    for (int i = 0; i < MEM_N; i++) mem[i] = pat(i);
    rst = 1'b1;
    trig = 1'b0;
    cb_base = 16'h0040;
    repeat (3) @(negedge clk);
    chk("R12", "done in reset", int'(done), 0);
    chk("R12", "err in reset", int'(err), 0);
    chk("R12", "mem_req in reset", int'(mem_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", "mem_req after reset", int'(mem_req), 0);

    // sweep: size x every keep/increment combination x count
    for (int sz = 0; sz < 2; sz++)
      for (int opt = 0; opt < 16; opt++)
        for (int c = 0; c < 2; c++)
          run("R2", {3'b100, sz[0], opt[3:0]}, (c == 0) ? 8'd1 : 8'd200,
              (sz == 1) ? 16'h0111 + 16'(opt * 4) : 16'h0110 + 16'(opt * 4),
              (sz == 1) ? 16'h0223 + 16'(opt * 4) : 16'h0220 + 16'(opt * 4),
              (opt[0]) ? 16'h0048 : 16'h0040);

    // R2: every other mode field value is rejected
    for (int m = 0; m < 8; m++)
      if (m != 4) run("R2", {m[2:0], 5'b11111}, 8'd5, 16'h0150, 16'h0260, 16'h0040);
    // R8: word with odd pointers
    run("R8", 8'h8F, 8'd5, 16'h0151, 16'h0260, 16'h0040);
    run("R8", 8'h8F, 8'd5, 16'h0150, 16'h0261, 16'h0040);
    // R9: exhausted count
    run("R9", 8'h9F, 8'd0, 16'h0150, 16'h0260, 16'h0040);
    // R10: misaligned control block base
    run("R10", 8'h9F, 8'd5, 16'h0150, 16'h0260, 16'h0043);

    // R11: two triggers during a busy transfer add exactly one more transfer
    load_cb(16'h0048, 8'h9F, 8'd5, 16'h0130, 16'h0240);
    cb_base = 16'h0048;
    d0 = n_done;
    e0 = n_err;
    pulse();
    repeat (3) @(negedge clk);
    pulse();
    repeat (2) @(negedge clk);
    pulse();
    repeat (80) @(negedge clk);
    chk("R11", "count after merged triggers", int'(mem[16'h0048]), 3);
    chk("R11", "src after two moves", int'({mem[16'h004B], mem[16'h004A]}), 16'h0132);
    chk("R11", "dst after two moves", int'({mem[16'h004D], mem[16'h004C]}), 16'h0242);
    chk("R11", "first byte", int'(mem[16'h0240]), int'(pat(16'h0130)));
    chk("R11", "second byte", int'(mem[16'h0241]), int'(pat(16'h0131)));
    chk("R11", "no third move", int'(mem[16'h0242]), 8'hEE);
    chk("R11", "no err", n_err - e0, 0);
    chk("R11", "no done", n_done - d0, 0);

    summary();
    $finish;
  end

endmodule